// File: doc/BRIEF.md
# Link Power State Controller

This block keeps track of the power state of one serial link port and moves it between four levels: active (U0), idle with a quick return (U1), idle with a slow return (U2) and suspended (U3). Two programmable inactivity timers push a quiet link from active into fast idle and then into slow idle. A setting of zero switches the matching timer off. Either end of the link can ask for a low-power level directly: the local side through `lp_req`, the far side through `peer_lp_req`. Suspend is entered only when a separate command asks for it.

Traffic is reported as a one-cycle strobe with a two-bit kind tag. Time-stamp packets, with kind value 3, are ignored: they neither restart the idle timers nor wake the link. Any other packet counts as pending traffic. When the link is in a low-power level, pending traffic or a detected wake signal from the partner starts an exit. An exit from fast idle lasts a fixed number of cycles. An exit from slow idle or from suspend lasts a run-time programmable number of cycles. While an exit started by local traffic is in progress, a wake-signal request is raised to the signalling layer.

Top module: `lpm_link_ctrl`

## Requirements
- R1: After reset the link reads U0 (`link_state` = 0), with `exiting` = 0 and `wake_req` = 0.
- R2: In U0, with no requests, the link moves to U1 (`link_state` = 1) at the u1_timeout-th clock edge after the last non-timestamp packet or after reset. If `u1_timeout` is 0, the link stays in U0.
- R3: In U1, the link moves to U2 (`link_state` = 2) at the u2_timeout-th edge after it entered U1. If `u2_timeout` is 0, the link stays in U1.
- R4: A packet strobe with `act_kind` = 3 (time stamp) does not restart either idle timer and does not start an exit.
- R5: A non-timestamp packet seen in U0 restarts the U1 count from zero, counted from the edge that captures it.
- R6: In U0, a request from the local side or from the partner moves the link on the next edge. The request's target bit (0 = U1, 1 = U2) picks the level. If both ends ask at once, the deeper target wins. A non-timestamp packet in the same cycle keeps the link in U0.
- R7: U3 (`link_state` = 3) is entered on the edge after `suspend_cmd` is seen in U0, U1 or U2. `suspend_cmd` takes priority over every other input. No timer ever leads to U3.
- R8: An exit from U1 holds `exiting` high for FAST_LAT cycles, with `link_state` still 1. After that the link reads U0.
- R9: An exit from U2 or U3 holds `exiting` high for `slow_exit_lat` cycles, and for 1 cycle when that setting is 0. After that the link reads U0.
- R10: `wake_req` is high for the whole of an exit that was started while a non-timestamp packet was present. It stays low for an exit started only by `wake_det`.
- R11: While `exiting` is high, packets, requests, `wake_det` and `suspend_cmd` have no effect on the exit length or on the state the link reaches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_vld | input | 1 | Packet strobe, one cycle per packet |
| act_kind | input | 2 | Packet kind; 3 = time stamp |
| lp_req | input | 1 | Local request for a low-power level |
| lp_tgt | input | 1 | Local target: 0 = U1, 1 = U2 |
| peer_lp_req | input | 1 | Partner request for a low-power level |
| peer_lp_tgt | input | 1 | Partner target: 0 = U1, 1 = U2 |
| suspend_cmd | input | 1 | Command to enter U3 |
| wake_det | input | 1 | Wake signalling detected from the partner |
| u1_timeout | input | TW | Idle cycles before U0 moves to U1; 0 = off |
| u2_timeout | input | TW | Cycles in U1 before the move to U2; 0 = off |
| slow_exit_lat | input | LW | Exit length from U2 or U3 in cycles |
| link_state | output | 2 | Current level: 0 = U0, 1 = U1, 2 = U2, 3 = U3 |
| exiting | output | 1 | An exit to U0 is in progress |
| wake_req | output | 1 | Request to send wake signalling |

## Verification
The bound checker watches the following on every cycle:
- U3 is never entered without `suspend_cmd`.
- A low-power level never drops to U0 without passing through an exit.
- The state does not change during an exit, except for the final return to U0.
- Time-stamp strobes never start an exit.
- A zero U1 setting keeps a quiet link in U0.
- U2 is not reached from U0 without a deep request.
- `wake_req` is never raised outside an exit.

Only the bench scenarios can show the exact cycle counts. These are the timer expiry edges for several settings, the restart of the count by real traffic, and the exit lengths for fast and slow exits, including the zero-latency floor. They also cover the priority between both requesters, and the source-dependent value of `wake_req`.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LS_U0 = 2'd0,
    LS_U1 = 2'd1,
    LS_U2 = 2'd2,
    LS_U3 = 2'd3
  } lstate_e;

  localparam logic [1:0] KIND_TSTAMP = 2'd3;

  // True on the cycle an idle count reaches its programmed limit.
  function automatic logic count_done(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt == lim - 32'd1);
  endfunction

  // Number of exit cycles for the level being left.
  function automatic logic [31:0] exit_span(input logic slow,
                                            input logic [31:0] fast_len,
                                            input logic [31:0] slow_len);
    if (!slow) return fast_len;
    if (slow_len == 32'd0) return 32'd1;
    return slow_len;
  endfunction

  // A strobe counts as pending traffic unless it is a time stamp.
  function automatic logic is_real_pkt(input logic vld, input logic [1:0] kind);
    return vld && (kind != KIND_TSTAMP);
  endfunction

endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign expire = run && !restart && lpm_pkg::count_done(32'(cnt), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!run || restart || expire) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_exit_timer.sv
module lpm_exit_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] span,
  output logic          busy,
  output logic          done
);
  logic [LW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= span - 1'b1;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lpm_state_fsm.sv
module lpm_state_fsm
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    real_pkt,
  input  logic    wake_det,
  input  logic    suspend_cmd,
  input  logic    lp_any,
  input  logic    lp_deep,
  input  logic    u1_expire,
  input  logic    u2_expire,
  input  logic    exit_busy,
  input  logic    exit_done,
  output lstate_e state,
  output logic    exit_start,
  output logic    wake_q
);
  lstate_e next;
  logic    wake_ev;

  assign wake_ev = real_pkt || wake_det;

  always_comb begin
    next       = state;
    exit_start = 1'b0;
    if (exit_busy) begin
      if (exit_done) next = LS_U0;
    end else begin
      unique case (state)
        LS_U0: begin
          if (suspend_cmd)    next = LS_U3;
          else if (real_pkt)  next = LS_U0;
          else if (lp_any)    next = lp_deep ? LS_U2 : LS_U1;
          else if (u1_expire) next = LS_U1;
        end
        LS_U1: begin
          if (suspend_cmd)    next = LS_U3;
          else if (wake_ev)   exit_start = 1'b1;
          else if (u2_expire) next = LS_U2;
        end
        LS_U2: begin
          if (suspend_cmd)  next = LS_U3;
          else if (wake_ev) exit_start = 1'b1;
        end
        LS_U3: begin
          if (wake_ev) exit_start = 1'b1;
        end
        default: next = LS_U0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LS_U0;
      wake_q <= 1'b0;
    end else begin
      state <= next;
      if (exit_start)     wake_q <= real_pkt;
      else if (exit_done) wake_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_link_ctrl.sv
module lpm_link_ctrl
  import lpm_pkg::*;
#(
  parameter int TW       = 16,
  parameter int LW       = 8,
  parameter int FAST_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_vld,
  input  logic [1:0]    act_kind,
  input  logic          lp_req,
  input  logic          lp_tgt,
  input  logic          peer_lp_req,
  input  logic          peer_lp_tgt,
  input  logic          suspend_cmd,
  input  logic          wake_det,
  input  logic [TW-1:0] u1_timeout,
  input  logic [TW-1:0] u2_timeout,
  input  logic [LW-1:0] slow_exit_lat,
  output logic [1:0]    link_state,
  output logic          exiting,
  output logic          wake_req
);
  localparam int NUM_TMR = 2;

  lstate_e              state;
  logic                 real_pkt;
  logic                 exit_start;
  logic                 exit_busy;
  logic                 exit_done;
  logic                 wake_q;
  logic                 lp_any;
  logic                 lp_deep;
  logic                 slow_sel;
  logic [LW-1:0]        span;
  logic [NUM_TMR-1:0]   tmr_run;
  logic [NUM_TMR-1:0]   tmr_exp;
  logic [TW-1:0]        tmr_lim [NUM_TMR];
  logic                 u1_expire;
  logic                 u2_expire;

  assign real_pkt = is_real_pkt(act_vld, act_kind);
  assign lp_any   = lp_req || peer_lp_req;
  assign lp_deep  = (lp_req && lp_tgt) || (peer_lp_req && peer_lp_tgt);

  assign tmr_lim[0] = u1_timeout;
  assign tmr_lim[1] = u2_timeout;
  assign tmr_run[0] = (state == LS_U0) && !exit_busy;
  assign tmr_run[1] = (state == LS_U1) && !exit_busy;

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    lpm_idle_timer #(.TW(TW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_run[gi]),
      .restart (real_pkt),
      .limit   (tmr_lim[gi]),
      .expire  (tmr_exp[gi])
    );
  end

  assign u1_expire = tmr_exp[0];
  assign u2_expire = tmr_exp[1];

  assign slow_sel = (state != LS_U1);
  assign span     = LW'(exit_span(slow_sel, 32'(FAST_LAT), 32'(slow_exit_lat)));

  lpm_exit_timer #(.LW(LW)) u_exit (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (exit_start),
    .span  (span),
    .busy  (exit_busy),
    .done  (exit_done)
  );

  lpm_state_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .real_pkt    (real_pkt),
    .wake_det    (wake_det),
    .suspend_cmd (suspend_cmd),
    .lp_any      (lp_any),
    .lp_deep     (lp_deep),
    .u1_expire   (u1_expire),
    .u2_expire   (u2_expire),
    .exit_busy   (exit_busy),
    .exit_done   (exit_done),
    .state       (state),
    .exit_start  (exit_start),
    .wake_q      (wake_q)
  );

  assign link_state = state;
  assign exiting    = exit_busy;
  assign wake_req   = wake_q;
endmodule

// File: rtl/lpm_link_ctrl_chk.sv
module lpm_link_ctrl_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_vld,
  input logic [1:0]    act_kind,
  input logic          lp_req,
  input logic          lp_tgt,
  input logic          peer_lp_req,
  input logic          peer_lp_tgt,
  input logic          suspend_cmd,
  input logic          wake_det,
  input logic [TW-1:0] u1_timeout,
  input logic [1:0]    link_state,
  input logic          exiting,
  input logic          wake_req,
  input logic          exit_start
);
  assert_u3_by_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state != 2'd3 && !exiting && !suspend_cmd) |=> (link_state != 2'd3));

  assert_exit_path_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state != 2'd0 && !exiting) |=> (link_state != 2'd0));

  assert_exit_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exiting |=> (link_state == $past(link_state) || link_state == 2'd0));

  assert_tstamp_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!exiting && link_state != 2'd0 && act_vld && act_kind == 2'd3 && !wake_det)
      |=> !exiting);

  assert_u1_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && u1_timeout == '0 && !lp_req && !peer_lp_req && !suspend_cmd)
      |=> (link_state == 2'd0));

  assert_no_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && !(lp_req && lp_tgt) && !(peer_lp_req && peer_lp_tgt))
      |=> (link_state != 2'd2));

  assert_wake_in_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> exiting);

  assert_start_leads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_start |=> (exiting && link_state == $past(link_state)));
endmodule

bind lpm_link_ctrl lpm_link_ctrl_chk #(.TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .act_vld     (act_vld),
  .act_kind    (act_kind),
  .lp_req      (lp_req),
  .lp_tgt      (lp_tgt),
  .peer_lp_req (peer_lp_req),
  .peer_lp_tgt (peer_lp_tgt),
  .suspend_cmd (suspend_cmd),
  .wake_det    (wake_det),
  .u1_timeout  (u1_timeout),
  .link_state  (link_state),
  .exiting     (exiting),
  .wake_req    (wake_req),
  .exit_start  (exit_start)
);

// File: tb/lpm_link_ctrl_bench.sv
module lpm_link_ctrl_bench;
  localparam int TW = 16;
  localparam int LW = 8;
  localparam int FAST = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_vld = 1'b0;
  logic [1:0]    act_kind = 2'd0;
  logic          lp_req = 1'b0, lp_tgt = 1'b0;
  logic          peer_lp_req = 1'b0, peer_lp_tgt = 1'b0;
  logic          suspend_cmd = 1'b0, wake_det = 1'b0;
  logic [TW-1:0] u1_timeout = '0, u2_timeout = '0;
  logic [LW-1:0] slow_exit_lat = '0;
  logic [1:0]    link_state;
  logic          exiting, wake_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpm_link_ctrl #(.TW(TW), .LW(LW), .FAST_LAT(FAST)) u_lpm_link_ctrl (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_kind(act_kind),
    .lp_req(lp_req), .lp_tgt(lp_tgt), .peer_lp_req(peer_lp_req),
    .peer_lp_tgt(peer_lp_tgt), .suspend_cmd(suspend_cmd), .wake_det(wake_det),
    .u1_timeout(u1_timeout), .u2_timeout(u2_timeout), .slow_exit_lat(slow_exit_lat),
    .link_state(link_state), .exiting(exiting), .wake_req(wake_req)
  );

  typedef struct packed {
    logic [15:0] t1;
    logic [15:0] t2;
    logic [7:0]  sl;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'd1,  16'd1,  8'd0},
    '{16'd3,  16'd2,  8'd1},
    '{16'd5,  16'd7,  8'd4},
    '{16'd12, 16'd3,  8'd9},
    '{16'd2,  16'd20, 8'd15},
    '{16'd30, 16'd1,  8'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    act_vld = 0; act_kind = 0; lp_req = 0; lp_tgt = 0;
    peer_lp_req = 0; peer_lp_tgt = 0; suspend_cmd = 0; wake_det = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Counts clock edges until link_state differs from its value now.
  task automatic edges_to_change(output int n);
    logic [1:0] s0;
    s0 = link_state;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (link_state == s0 && n < 5000);
  endtask

  // One-cycle wake event, then edges until the state changes.
  task automatic wake_and_count(input bit traf, input bit wk, output int n, output int seen);
    logic [1:0] s0;
    s0 = link_state;
    act_vld = traf; act_kind = 2'd0; wake_det = wk;
    n = 0; seen = 0;
    do begin
      @(negedge clk);
      act_vld = 0; wake_det = 0;
      n++;
      if (wake_req) seen = 1;
    end while (link_state == s0 && n < 5000);
  endtask

  task automatic pulse_req(input bit l, input bit lt, input bit p, input bit pt);
    lp_req = l; lp_tgt = lt; peer_lp_req = p; peer_lp_tgt = pt;
    @(negedge clk);
    lp_req = 0; lp_tgt = 0; peer_lp_req = 0; peer_lp_tgt = 0;
  endtask

  initial begin
    int n, seen, exp_lat;
    // R1 reset values
    u1_timeout = 16'd0; u2_timeout = 16'd0;
    do_reset();
    chk(link_state == 2'd0, "R1 reset state", link_state, 0);
    chk(exiting == 1'b0,    "R1 reset exiting", exiting, 0);
    chk(wake_req == 1'b0,   "R1 reset wake_req", wake_req, 0);

    // Table walk: timer expiry and slow exit for each setting
    for (int i = 0; i < 6; i++) begin
      u1_timeout = VEC[i].t1; u2_timeout = VEC[i].t2; slow_exit_lat = VEC[i].sl;
      do_reset();
      edges_to_change(n);
      chk(n == int'(VEC[i].t1) && link_state == 2'd1, "R2 U0->U1 edges", n, VEC[i].t1);
      edges_to_change(n);
      chk(n == int'(VEC[i].t2) && link_state == 2'd2, "R3 U1->U2 edges", n, VEC[i].t2);
      u1_timeout = 16'd0;
      exp_lat = (VEC[i].sl == 0) ? 1 : int'(VEC[i].sl);
      // one edge to capture the packet, then exp_lat exit cycles
      wake_and_count(1'b1, 1'b0, n, seen);
      chk(n == exp_lat + 1 && link_state == 2'd0, "R9 slow exit edges", n, exp_lat + 1);
      chk(seen == 1, "R10 wake_req on local exit", seen, 1);
    end

    // R2 zero disables U1 entry
    u1_timeout = 16'd0; u2_timeout = 16'd5;
    do_reset();
    repeat (300) @(negedge clk);
    chk(link_state == 2'd0, "R2 zero timeout stays U0", link_state, 0);

    // R6 local shallow request, then R3 zero keeps U1, R4 timestamp in U1
    pulse_req(1, 0, 0, 0);
    chk(link_state == 2'd1, "R6 local request to U1", link_state, 1);
    u2_timeout = 16'd0;
    repeat (200) @(negedge clk);
    chk(link_state == 2'd1, "R3 zero timeout stays U1", link_state, 1);
    act_vld = 1; act_kind = 2'd3;
    @(negedge clk);
    act_vld = 0; act_kind = 2'd0;
    repeat (3) @(negedge clk);
    chk(link_state == 2'd1 && !exiting, "R4 timestamp does not wake", {exiting, link_state}, 1);
    // R8 fast exit via partner wake, R10 no wake_req
    wake_and_count(1'b0, 1'b1, n, seen);
    chk(n == FAST + 1 && link_state == 2'd0, "R8 fast exit edges", n, FAST + 1);
    chk(seen == 0, "R10 no wake_req on partner exit", seen, 0);

    // R6 partner deep request and mixed requests
    u1_timeout = 16'd0; slow_exit_lat = 8'd6;
    do_reset();
    pulse_req(0, 0, 1, 1);
    chk(link_state == 2'd2, "R6 partner deep request to U2", link_state, 2);
    wake_and_count(1'b1, 1'b0, n, seen);
    chk(n == 7 && link_state == 2'd0, "R9 exit from U2 lat 6", n, 7);
    pulse_req(1, 0, 1, 1);
    chk(link_state == 2'd2, "R6 deeper target wins", link_state, 2);
    wake_and_count(1'b0, 1'b1, n, seen);
    act_vld = 1; act_kind = 2'd1;
    pulse_req(1, 1, 0, 0);
    act_vld = 0; act_kind = 2'd0;
    chk(link_state == 2'd0, "R6 traffic beats request", link_state, 0);

    // R4 timestamps in U0 do not restart the count
    u1_timeout = 16'd10;
    do_reset();
    n = 0;
    do begin
      act_vld = (n % 3 == 1); act_kind = 2'd3;
      @(negedge clk);
      n++;
    end while (link_state == 2'd0 && n < 5000);
    act_vld = 0; act_kind = 2'd0;
    chk(n == 10, "R4 timestamps ignored by U1 timer", n, 10);

    // R5 real packet restarts the count
    do_reset();
    repeat (6) @(negedge clk);
    wake_and_count(1'b1, 1'b0, n, seen);
    chk(n == 11 && link_state == 2'd1, "R5 restart by packet", n, 11);

    // R7 suspend from U1, timers never leave U3, wake from U3 with lat 0
    u1_timeout = 16'd0; u2_timeout = 16'd0; slow_exit_lat = 8'd0;
    do_reset();
    pulse_req(1, 0, 0, 0);
    suspend_cmd = 1; wake_det = 1;
    @(negedge clk);
    suspend_cmd = 0; wake_det = 0;
    chk(link_state == 2'd3 && !exiting, "R7 suspend wins to U3", link_state, 3);
    u1_timeout = 16'd1; u2_timeout = 16'd1;
    repeat (50) @(negedge clk);
    chk(link_state == 2'd3, "R7 timers do not leave U3", link_state, 3);
    wake_and_count(1'b0, 1'b1, n, seen);
    chk(n == 2 && link_state == 2'd0, "R9 exit from U3 lat 0", n, 2);

    // R11 inputs ignored during exit
    u1_timeout = 16'd0; u2_timeout = 16'd0;
    do_reset();
    pulse_req(1, 0, 0, 0);
    wake_det = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      wake_det = 0;
      if (link_state != 2'd0) begin
        suspend_cmd = 1; act_vld = 1; act_kind = 2'd0; lp_req = 1; lp_tgt = 1;
      end
    end while (link_state != 2'd0 && n < 5000);
    suspend_cmd = 0; act_vld = 0; lp_req = 0; lp_tgt = 0;
    chk(n == FAST + 1 && link_state == 2'd0, "R11 exit unaffected", n, FAST + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule